// File: doc/BRIEF.md
# Aliased Set/Clear/Toggle Control Register Bank

This block is a memory-mapped bank of 32-bit control words placed in a 64 KiB window. Each word owns a 16-byte slot. The four word-aligned offsets inside a slot are aliases of the same storage. A write through one of them replaces the word, sets bits, clears bits or flips bits, depending on which alias is used. Because of this, software can change a single field without first reading the word back.

The window holds two groups. The first is a group of clock-synthesiser control and fraction words, which come out of reset with fixed settings and with their lock flag raised. The second is a group of power-management words, which reset to zero. A fixed, read-only identification word sits at one address inside the power-management range and takes priority there. The bus port is synchronous: read data and the error flag appear one cycle after the access.

Top module: `sct_regbank`

## Requirements
- R1: A write at a slot offset with addr[3:2]=00 replaces the addressed word with wdata; a read issued in the following cycle returns the new value.
- R2: A write with addr[3:2]=01 ORs wdata into the word; bits that are zero in wdata keep their value.
- R3: A write with addr[3:2]=10 clears every bit of the word that is one in wdata, across all 32 bits.
- R4: A write with addr[3:2]=11 inverts every bit of the word that is one in wdata; two equal toggles restore the word.
- R5: A read at any of the four aliases of a slot returns the stored word unchanged. rdata is registered, updates only in the cycle after rd_en and otherwise holds.
- R6: An access with addr[1:0] not 00 changes no word, returns zero on a read, and raises err for one cycle.
- R7: Slot k of the synthesiser group starts at 0x60+16k (k<26), and slot k of the power group starts at 0x200+16k (k<128). An access outside both groups changes nothing, reads zero, and raises err.
- R8: Address 0x800 reads 0x00720010. A write there raises err and leaves power slot 96 untouched, while 0x804, 0x808 and 0x80C reach power slot 96.
- R9: After reset every word is zero except the synthesiser slots: 0:0x80002042, 1:0x8060302C, 3:0x06AAAC4D, 4:0x100003EC, 5:0x80002000, 6:0xD2605A56, 7:0xD2525216, 8:0x80001FC0, 9:0x8001301B, 11:0x05F5E100, 12:0x2964619C, 13:0x8008201B, 15:0x0000F699, 16:0x000F4240, 17:0x80000000. Bit 31 is the lock flag of the nine control slots.
- R10: When rd_en and wr_en are both high for the same address, the read returns the value from before the write.
- R11: err is high only in the cycle after a faulty access and is low after idle cycles and after valid accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Byte address within the window |
| wdata | input | 32 | Write data or bit mask |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle fault flag for the previous access |

## Verification
The assertions assume that the inputs are quiet while reset is held and during the first edge after it. They also assume that addr and the strobes are stable around each rising edge. The bench drives every input on the falling edge and keeps the strobes low through reset, so both conditions hold. Addresses are drawn from the mapped groups, from the identification word, from misaligned offsets and from unmapped space, so every decode branch is reached under the same timing assumptions.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int WORD_W     = 32;
  localparam int SLOT_BYTES = 16;
  localparam int LOCK_BIT   = 31;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_TOGGLE = 2'b11
  } alias_op_e;

  function automatic logic [WORD_W-1:0] apply_alias(alias_op_e op,
                                                   logic [WORD_W-1:0] cur,
                                                   logic [WORD_W-1:0] data);
    case (op)
      OP_SET:    return cur | data;
      OP_CLEAR:  return cur & ~data;
      OP_TOGGLE: return cur ^ data;
      default:   return data;
    endcase
  endfunction

  function automatic logic is_synth_ctrl(int idx);
    case (idx)
      0, 1, 5, 6, 7, 8, 9, 13, 17: return 1'b1;
      default:                     return 1'b0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] synth_default(int idx);
    logic [WORD_W-1:0] v;
    case (idx)
      0:  v = 32'h0000_2042;
      1:  v = 32'h0060_302C;
      3:  v = 32'h06AA_AC4D;
      4:  v = 32'h1000_03EC;
      5:  v = 32'h0000_2000;
      6:  v = 32'h5260_5A56;
      7:  v = 32'h5252_5216;
      8:  v = 32'h0000_1FC0;
      9:  v = 32'h0001_301B;
      11: v = 32'h05F5_E100;
      12: v = 32'h2964_619C;
      13: v = 32'h0008_201B;
      15: v = 32'h0000_F699;
      16: v = 32'h000F_4240;
      default: v = '0;
    endcase
    if (is_synth_ctrl(idx)) v[LOCK_BIT] = 1'b1;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] init_word(bit synth_group, int idx);
    return synth_group ? synth_default(idx) : '0;
  endfunction
endpackage

// File: rtl/sct_decode.sv
module sct_decode
  import sct_pkg::*;
#(
  parameter int AW       = 16,
  parameter int A_BASE   = 'h60,
  parameter int A_REGS   = 26,
  parameter int P_BASE   = 'h200,
  parameter int P_REGS   = 128,
  parameter int ID_ADDR  = 'h800,
  localparam int A_IW    = (A_REGS > 1) ? $clog2(A_REGS) : 1,
  localparam int P_IW    = (P_REGS > 1) ? $clog2(P_REGS) : 1
) (
  input  logic [AW-1:0]   addr,
  output logic            misalign,
  output logic            hit_id,
  output logic            hit_a,
  output logic            hit_p,
  output logic [A_IW-1:0] a_idx,
  output logic [P_IW-1:0] p_idx,
  output alias_op_e       op
);
  localparam int A_END = A_BASE + A_REGS * SLOT_BYTES;
  localparam int P_END = P_BASE + P_REGS * SLOT_BYTES;

  logic [AW-1:0] a_off, p_off;
  int            addr_i;

  always_comb begin
    addr_i   = int'(addr);
    a_off    = addr - AW'(A_BASE);
    p_off    = addr - AW'(P_BASE);
    misalign = addr[1:0] != 2'b00;
    hit_id   = addr_i == ID_ADDR;
    hit_a    = (addr_i >= A_BASE) && (addr_i < A_END);
    hit_p    = (addr_i >= P_BASE) && (addr_i < P_END) && !hit_id;
    a_idx    = a_off[A_IW+3:4];
    p_idx    = p_off[P_IW+3:4];
    op       = alias_op_e'(addr[3:2]);
  end
endmodule

// File: rtl/sct_bank.sv
module sct_bank
  import sct_pkg::*;
#(
  parameter int  REGS  = 26,
  parameter bit  SYNTH = 1'b1,
  localparam int IW    = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  alias_op_e         op,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] regs [REGS];

  for (genvar g = 0; g < REGS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= init_word(SYNTH, g);
      else if (we && (int'(idx) == g))
        regs[g] <= apply_alias(op, regs[g], wdata);
    end
  end

  always_comb rd_word = (int'(idx) < REGS) ? regs[idx] : '0;

  assert_plain_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_WRITE) |=> regs[$past(idx)] == $past(wdata));
  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_SET) |=> (regs[$past(idx)] & $past(wdata)) == $past(wdata));
  assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_CLEAR) |=> (regs[$past(idx)] & $past(wdata)) == '0);
  assert_toggle_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_TOGGLE) |=> regs[$past(idx)] == ($past(rd_word) ^ $past(wdata)));
endmodule

// File: rtl/sct_regbank.sv
module sct_regbank
  import sct_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          A_BASE   = 'h60,
  parameter int          A_REGS   = 26,
  parameter int          P_BASE   = 'h200,
  parameter int          P_REGS   = 128,
  parameter int          ID_ADDR  = 'h800,
  parameter logic [31:0] ID_VALUE = 32'h0072_0010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [31:0]   rdata,
  output logic          err
);
  localparam int A_IW = (A_REGS > 1) ? $clog2(A_REGS) : 1;
  localparam int P_IW = (P_REGS > 1) ? $clog2(P_REGS) : 1;

  logic            misalign, hit_id, hit_a, hit_p;
  logic [A_IW-1:0] a_idx;
  logic [P_IW-1:0] p_idx;
  alias_op_e       op;
  logic            access, fault, a_we, p_we;
  logic [31:0]     a_word, p_word, rd_val;

  sct_decode #(
    .AW(AW), .A_BASE(A_BASE), .A_REGS(A_REGS),
    .P_BASE(P_BASE), .P_REGS(P_REGS), .ID_ADDR(ID_ADDR)
  ) u_dec (
    .addr(addr), .misalign(misalign), .hit_id(hit_id), .hit_a(hit_a),
    .hit_p(hit_p), .a_idx(a_idx), .p_idx(p_idx), .op(op)
  );

  always_comb begin
    access = rd_en || wr_en;
    fault  = misalign || !(hit_a || hit_p || hit_id) || (wr_en && hit_id);
    a_we   = wr_en && !misalign && hit_a;
    p_we   = wr_en && !misalign && hit_p;
    if (misalign)   rd_val = '0;
    else if (hit_id) rd_val = ID_VALUE;
    else if (hit_a)  rd_val = a_word;
    else if (hit_p)  rd_val = p_word;
    else             rd_val = '0;
  end

  sct_bank #(.REGS(A_REGS), .SYNTH(1'b1)) u_synth (
    .clk(clk), .rst_n(rst_n), .we(a_we), .idx(a_idx), .op(op),
    .wdata(wdata), .rd_word(a_word)
  );

  sct_bank #(.REGS(P_REGS), .SYNTH(1'b0)) u_power (
    .clk(clk), .rst_n(rst_n), .we(p_we), .idx(p_idx), .op(op),
    .wdata(wdata), .rd_word(p_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= access && fault;
      if (rd_en) rdata <= rd_val;
    end
  end

  assert_unaligned_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (access && addr[1:0] != 2'b00) |=> err);
  assert_unaligned_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |-> !(a_we || p_we));
  assert_single_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_we, p_we}));
  assert_id_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && int'(addr) == ID_ADDR) |=> rdata == ID_VALUE);
  assert_id_write_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == ID_ADDR) |=> err);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> !err);
  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_sct_regbank.sv
module tb_sct_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rdata;
  logic        err;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R9";

  always #2.5 clk = ~clk;

  sct_regbank dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                   .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .err(err));

  // Behavioural reference model
  logic [31:0] m_syn [26];
  logic [31:0] m_pwr [128];
  logic [31:0] exp_rdata = '0;
  logic        exp_err = 1'b0;

  task automatic model_reset();
    foreach (m_syn[i]) m_syn[i] = 32'h0;
    foreach (m_pwr[i]) m_pwr[i] = 32'h0;
    m_syn[0]  = 32'h8000_2042; m_syn[1]  = 32'h8060_302C;
    m_syn[3]  = 32'h06AA_AC4D; m_syn[4]  = 32'h1000_03EC;
    m_syn[5]  = 32'h8000_2000; m_syn[6]  = 32'hD260_5A56;
    m_syn[7]  = 32'hD252_5216; m_syn[8]  = 32'h8000_1FC0;
    m_syn[9]  = 32'h8001_301B; m_syn[11] = 32'h05F5_E100;
    m_syn[12] = 32'h2964_619C; m_syn[13] = 32'h8008_201B;
    m_syn[15] = 32'h0000_F699; m_syn[16] = 32'h000F_4240;
    m_syn[17] = 32'h8000_0000;
    exp_rdata = 0; exp_err = 0;
  endtask

  function automatic logic [31:0] combine(int kind, logic [31:0] o, logic [31:0] d);
    if (kind == 1) return o | d;
    if (kind == 2) return o & ~d;
    if (kind == 3) return o ^ d;
    return d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int a, kind, grp, slot;
      logic [31:0] cur;
      a = addr; kind = (a % 16) / 4; grp = 0; slot = 0; cur = 0;
      if (a % 4 != 0) grp = 0;
      else if (a == 2048) grp = 3;
      else if (a >= 96 && a < 512) begin grp = 1; slot = (a - 96) / 16; end
      else if (a >= 512 && a < 2560) begin grp = 2; slot = (a - 512) / 16; end
      if (grp == 1) cur = m_syn[slot];
      else if (grp == 2) cur = m_pwr[slot];
      else if (grp == 3) cur = 32'h0072_0010;
      if (rd_en || wr_en) exp_err = (grp == 0) || (grp == 3 && wr_en);
      else exp_err = 0;
      if (rd_en) exp_rdata = cur;
      if (wr_en && grp == 1) m_syn[slot] = combine(kind, cur, wdata);
      if (wr_en && grp == 2) m_pwr[slot] = combine(kind, cur, wdata);
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (rdata !== exp_rdata) begin
      fails++;
      $display("FAIL %s rdata actual %h expected %h", cur_req, rdata, exp_rdata);
    end
    checks++;
    if (err !== exp_err) begin
      fails++;
      $display("FAIL %s err actual %b expected %b", cur_req, err, exp_err);
    end
  end

  task automatic acc(input logic [15:0] a, input logic [31:0] d,
                     input logic w, input logic r);
    @(negedge clk);
    addr = a; wdata = d; wr_en = w; rd_en = r;
  endtask
  task automatic wr(input logic [15:0] a, input logic [31:0] d); acc(a, d, 1, 0); endtask
  task automatic rd(input logic [15:0] a); acc(a, 0, 0, 1); endtask
  task automatic idle(); acc(0, 0, 0, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();
    cur_req = "R9";   // reset contents of both groups
    for (int k = 0; k < 26; k++) rd(16'(96 + 16 * k));
    for (int k = 0; k < 128; k += 9) rd(16'(512 + 16 * k));
    cur_req = "R1";
    wr(16'h0070, 32'hA5A5_0F0F); rd(16'h0070);
    cur_req = "R5";
    rd(16'h0074); rd(16'h0078); rd(16'h007C); idle(); idle();
    cur_req = "R2";
    wr(16'h0074, 32'h5000_00F0); rd(16'h0070);
    cur_req = "R3";
    wr(16'h0078, 32'hFFFF_0001); rd(16'h0070);
    wr(16'h0068, 32'hFFFF_FFFF); rd(16'h0060);
    cur_req = "R4";
    wr(16'h007C, 32'h1234_5678); rd(16'h0070);
    wr(16'h007C, 32'h1234_5678); rd(16'h007C);
    wr(16'h021C, 32'h8000_0001); rd(16'h0210);
    cur_req = "R6";
    wr(16'h0061, 32'hDEAD_BEEF); rd(16'h0060);
    rd(16'h0202); wr(16'h020E, 32'h1); rd(16'h0200);
    cur_req = "R7";
    wr(16'h0000, 32'hFFFF_FFFF); rd(16'h0000);
    wr(16'h0050, 32'h1); rd(16'h005C);
    wr(16'h0A00, 32'h1); rd(16'h0A00); rd(16'hFFF0);
    rd(16'h01F0); rd(16'h09F0);
    cur_req = "R8";
    wr(16'h0800, 32'hFFFF_FFFF); rd(16'h0800); rd(16'h0804);
    wr(16'h0804, 32'h0000_00F0); rd(16'h0800); rd(16'h0808);
    wr(16'h080C, 32'h0000_0030); rd(16'h0800); rd(16'h0804);
    cur_req = "R10";
    acc(16'h0090, 32'hCAFE_0001, 1, 1); rd(16'h0090);
    acc(16'h0094, 32'h0000_FF00, 1, 1); acc(16'h0098, 32'h1, 1, 1); rd(16'h0090);
    cur_req = "R11";
    idle(); idle(); rd(16'h0060); idle();
    for (int n = 0; n < 400; n++) begin
      int pick;
      logic [15:0] a;
      pick = $urandom_range(0, 9);
      if (pick < 4)      a = 16'(96 + 16 * $urandom_range(0, 25) + 4 * $urandom_range(0, 3));
      else if (pick < 8) a = 16'(512 + 16 * $urandom_range(0, 127) + 4 * $urandom_range(0, 3));
      else if (pick == 8) a = 16'h0800;
      else               a = 16'($urandom);
      acc(a, $urandom, 1'($urandom), 1'($urandom));
    end
    idle(); idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule